// File: doc/BRIEF.md
# Single-Byte Copy Sequencer over Aligned 64-bit Memory

This block moves one byte from any source byte address to any destination byte address. The memory behind it only accepts whole 64-bit reads and writes on 8-byte boundaries, and it has no byte enables. A single-byte store is therefore built as a read-modify-write. The block fetches the quadword holding the source byte and isolates that byte. It then fetches the quadword holding the destination byte, opens a hole in the target lane and drops the source byte into it. Finally it writes the whole quadword back.

A one-cycle `start` pulse carries both addresses. `busy` stays high while the copy runs. `done` pulses for one cycle after the write has been accepted. Every memory access uses a valid/ready request channel. Read data returns on a separate response strobe one cycle after the read is accepted.

Top module: `qw_byte_mover`

## Requirements
- R1: Every memory request address equals the operand byte address with its low 3 bits forced to zero.
- R2: The low 3 bits of a byte address select the lane inside its quadword. Lane n occupies data bits [8n+7:8n], so lane 0 is the least significant byte.
- R3: Each copy issues exactly three accepted requests in a fixed order: a read of the source quadword, then a read of the destination quadword, then a write of the destination quadword. The write is requested only after both read responses have arrived.
- R4: In the written quadword, the destination lane holds the byte found in the source lane.
- R5: The other seven lanes of the written quadword equal the data returned by the destination read.
- R6: When source and destination share a quadword, including equal addresses, the destination read is issued after the source byte has been captured. The stored result is therefore that quadword with only the destination lane replaced.
- R7: A `start` pulse while `busy` is high is ignored. It causes no extra memory request and does not change the copy in progress.
- R8: `done` is high for exactly one cycle: the cycle after the write request is accepted. `busy` is high from the cycle after an accepted `start` through the `done` cycle.
- R9: While a request is valid but not yet accepted, its valid, address, direction and write data stay unchanged.
- R10: Copying from byte 0x103 of a quadword 0x0123456789ABCDEF to byte 0x20d of a quadword 0xFFEEDDCCBBAA9988 leaves 0xFFEE89CCBBAA9988 at quadword 0x208.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a copy |
| src_addr | input | ADDR_W | Source byte address, sampled with start |
| dst_addr | input | ADDR_W | Destination byte address, sampled with start |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Quadword-aligned byte address |
| mem_req_wdata | output | 64 | Write data, lane 0 in bits 7:0 |
| mem_rsp_valid | input | 1 | Read data valid, one cycle after read acceptance |
| mem_rsp_data | input | 64 | Read data |

## Verification
Two of the block's functions can land in the same cycle. One is the handling of a new `start`. The other is the copy that is already in flight, sitting on a request that memory is stalling with `ready` held low. The bench provokes this by pulsing `start` with unrelated addresses while a stalled request is pending. It judges the outcome by the log of accepted requests (exactly three, in order, at the first copy's addresses), by memory contents compared against a bench-side model, and by a single `done` pulse. The sweep over all 64 source/destination lane pairs runs both in separate quadwords and within one shared quadword. This confirms that the source extract always precedes the destination read.

// File: rtl/qbm_pkg.sv
package qbm_pkg;
    localparam int BYTE_W     = 8;
    localparam int LANES      = 8;
    localparam int QW_W       = LANES * BYTE_W;
    localparam int LANE_IDX_W = $clog2(LANES);

    typedef logic [QW_W-1:0]       qword_t;
    typedef logic [LANE_IDX_W-1:0] lane_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC_REQ,
        ST_SRC_WAIT,
        ST_DST_REQ,
        ST_DST_WAIT,
        ST_WR_REQ,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic valid;
        logic write;
        logic use_dst;
    } mem_cmd_t;

    function automatic qword_t lane_mask(lane_t lane);
        qword_t m;
        m = '0;
        m[lane*BYTE_W +: BYTE_W] = '1;
        return m;
    endfunction
endpackage

// File: rtl/qbm_extract.sv
module qbm_extract
    import qbm_pkg::*;
(
    input  qword_t qw_in,
    input  lane_t  lane,
    output qword_t byte_zx
);
    logic [LANES-1:0][BYTE_W-1:0] lanes_v;
    logic [BYTE_W-1:0]            picked;

    always_comb lanes_v = qw_in;
    assign picked  = lanes_v[lane];
    assign byte_zx = {{(QW_W-BYTE_W){1'b0}}, picked};
endmodule

// File: rtl/qbm_merge.sv
module qbm_merge
    import qbm_pkg::*;
(
    input  qword_t dst_qw,
    input  qword_t byte_zx,
    input  lane_t  lane,
    output qword_t merged
);
    qword_t hole_mask;
    qword_t cleared;
    qword_t positioned;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hole_mask[g*BYTE_W +: BYTE_W] = (lane == lane_t'(g)) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
    end

    assign cleared    = dst_qw & ~hole_mask;
    assign positioned = byte_zx << (int'(lane) * BYTE_W);
    assign merged     = cleared | positioned;
endmodule

// File: rtl/qbm_ctrl.sv
module qbm_ctrl
    import qbm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     req_ready,
    input  logic     rsp_valid,
    output mem_cmd_t cmd,
    output logic     load_ops,
    output logic     cap_src,
    output logic     cap_dst,
    output logic     busy,
    output logic     done
);
    seq_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:     if (start)     nxt = ST_SRC_REQ;
            ST_SRC_REQ:  if (req_ready) nxt = ST_SRC_WAIT;
            ST_SRC_WAIT: if (rsp_valid) nxt = ST_DST_REQ;
            ST_DST_REQ:  if (req_ready) nxt = ST_DST_WAIT;
            ST_DST_WAIT: if (rsp_valid) nxt = ST_WR_REQ;
            ST_WR_REQ:   if (req_ready) nxt = ST_DONE;
            ST_DONE:                    nxt = ST_IDLE;
            default:                    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd.valid   = (state == ST_SRC_REQ) || (state == ST_DST_REQ) || (state == ST_WR_REQ);
        cmd.write   = (state == ST_WR_REQ);
        cmd.use_dst = (state != ST_SRC_REQ);
    end

    assign load_ops = (state == ST_IDLE) && start;
    assign cap_src  = (state == ST_SRC_WAIT) && rsp_valid;
    assign cap_dst  = (state == ST_DST_WAIT) && rsp_valid;
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);
endmodule

// File: rtl/qw_byte_mover.sv
module qw_byte_mover
    import qbm_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    output logic              busy,
    output logic              done,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [63:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);
    localparam int HI_W = ADDR_W - LANE_IDX_W;

    mem_cmd_t          cmd;
    logic              load_ops, cap_src, cap_dst;
    logic [ADDR_W-1:0] src_q, dst_q, sel_addr;
    qword_t            byte_q, wr_q, byte_next, merged_next;

    qbm_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_ready (mem_req_ready),
        .rsp_valid (mem_rsp_valid),
        .cmd       (cmd),
        .load_ops  (load_ops),
        .cap_src   (cap_src),
        .cap_dst   (cap_dst),
        .busy      (busy),
        .done      (done)
    );

    qbm_extract u_extract (
        .qw_in   (mem_rsp_data),
        .lane    (src_q[LANE_IDX_W-1:0]),
        .byte_zx (byte_next)
    );

    qbm_merge u_merge (
        .dst_qw  (mem_rsp_data),
        .byte_zx (byte_q),
        .lane    (dst_q[LANE_IDX_W-1:0]),
        .merged  (merged_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            byte_q <= '0;
            wr_q   <= '0;
        end else begin
            if (load_ops) begin
                src_q <= src_addr;
                dst_q <= dst_addr;
            end
            if (cap_src) byte_q <= byte_next;
            if (cap_dst) wr_q   <= merged_next;
        end
    end

    assign sel_addr      = cmd.use_dst ? dst_q : src_q;
    assign mem_req_valid = cmd.valid;
    assign mem_req_write = cmd.write;
    assign mem_req_addr  = {sel_addr[ADDR_W-1 -: HI_W], {LANE_IDX_W{1'b0}}};
    assign mem_req_wdata = wr_q;
endmodule

// File: rtl/qbm_checker.sv
module qbm_checker
    import qbm_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              busy,
    input logic              done,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [63:0]       mem_req_wdata,
    input logic              mem_rsp_valid,
    input logic [63:0]       mem_rsp_data
);
    lane_t      dst_lane_c;
    logic [1:0] rsp_cnt;
    qword_t     last_rsp;

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_lane_c <= '0;
            rsp_cnt    <= '0;
            last_rsp   <= '0;
        end else begin
            if (start && !busy) begin
                dst_lane_c <= dst_addr[LANE_IDX_W-1:0];
                rsp_cnt    <= '0;
            end else if (mem_rsp_valid && rsp_cnt != 2'd3) begin
                rsp_cnt <= rsp_cnt + 2'd1;
            end
            if (mem_rsp_valid) last_rsp <= mem_rsp_data;
        end
    end

    assert_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[LANE_IDX_W-1:0] == '0));

    assert_write_after_reads_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (rsp_cnt == 2'd2));

    assert_reads_first_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_write) |-> (rsp_cnt < 2'd2));

    assert_keep_lanes_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |->
        (((mem_req_wdata ^ last_rsp) & ~lane_mask(dst_lane_c)) == '0));

    assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_req_valid && mem_req_ready && mem_req_write));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));
endmodule

bind qw_byte_mover qbm_checker #(.ADDR_W(ADDR_W)) u_qbm_checker (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .dst_addr      (dst_addr),
    .busy          (busy),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
);

// File: tb/tb_qw_byte_mover.sv
module tb_qw_byte_mover;
    localparam int AW    = 12;
    localparam int NQW   = 1 << (AW - 3);
    localparam int LOG_N = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] src_addr = '0, dst_addr = '0;
    logic          busy, done;
    logic          mem_req_valid, mem_req_ready, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [63:0]   mem_req_wdata;
    logic          mem_rsp_valid;
    logic [63:0]   mem_rsp_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic stall_mode = 1'b0;

    always #4 clk = ~clk;

    qw_byte_mover #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
        .busy(busy), .done(done),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [63:0] seed_qw(int i);
        if (i == 32) return 64'h0123456789ABCDEF;
        if (i == 65) return 64'hFFEEDDCCBBAA9988;
        return 64'hD1B54A32D192ED03 * 64'(i + 7) ^ 64'(i);
    endfunction

    // memory model and access monitor
    logic [63:0] mem [0:NQW-1];
    logic [63:0] ref_mem [0:NQW-1];
    logic [15:0] lfsr;
    logic        log_wr   [0:LOG_N-1];
    logic [AW-1:0] log_addr [0:LOG_N-1];
    int acc_total = 0, done_total = 0, cyc = 0, done_cyc = 0, wr_cyc = 0;

    assign mem_req_ready = !stall_mode || lfsr[0] || lfsr[5];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            lfsr          <= 16'hACE1;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            for (int i = 0; i < NQW; i++) mem[i] <= seed_qw(i);
        end else begin
            lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_write;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    mem[mem_req_addr >> 3] <= mem_req_wdata;
                    wr_cyc <= cyc;
                end else begin
                    mem_rsp_data <= mem[mem_req_addr >> 3];
                end
                log_wr[acc_total % LOG_N]   <= mem_req_write;
                log_addr[acc_total % LOG_N] <= mem_req_addr;
                acc_total <= acc_total + 1;
            end
            if (done) begin
                done_total <= done_total + 1;
                done_cyc   <= cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic run_op(input logic [AW-1:0] s, input logic [AW-1:0] d, input bit poke_busy);
        int base, dbase, waited, mism;
        logic [7:0] sb;
        base  = acc_total;
        dbase = done_total;
        // bench model of the copy: R2 lane n = bits 8n+7:8n
        sb = ref_mem[s >> 3][8*s[2:0] +: 8];
        ref_mem[d >> 3][8*d[2:0] +: 8] = sb;
        @(negedge clk);
        start = 1'b1; src_addr = s; dst_addr = d;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", 64'(busy), 64'd1);
        if (poke_busy) begin
            repeat (2) @(negedge clk);
            start = 1'b1; src_addr = ~s; dst_addr = ~d;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (done_total == dbase && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        chk(waited < 400, "R8 done seen", 64'(waited), 64'd0);
        repeat (3) @(negedge clk);
        chk(done_total - dbase == 1, "R8 R7 single done", 64'(done_total - dbase), 64'd1);
        chk(done_cyc - wr_cyc == 1, "R8 done cycle after write", 64'(done_cyc - wr_cyc), 64'd1);
        chk(busy == 1'b0, "R8 idle after done", 64'(busy), 64'd0);
        chk(acc_total - base == 3, "R3 R7 access count", 64'(acc_total - base), 64'd3);
        chk(log_wr[base % LOG_N] == 0 && log_addr[base % LOG_N] == {s[AW-1:3], 3'b0},
            "R1 R3 first access src read", 64'(log_addr[base % LOG_N]), 64'({s[AW-1:3], 3'b0}));
        chk(log_wr[(base+1) % LOG_N] == 0 && log_addr[(base+1) % LOG_N] == {d[AW-1:3], 3'b0},
            "R1 R3 R6 second access dst read", 64'(log_addr[(base+1) % LOG_N]), 64'({d[AW-1:3], 3'b0}));
        chk(log_wr[(base+2) % LOG_N] == 1 && log_addr[(base+2) % LOG_N] == {d[AW-1:3], 3'b0},
            "R1 R3 third access dst write", 64'(log_addr[(base+2) % LOG_N]), 64'({d[AW-1:3], 3'b0}));
        mism = 0;
        for (int i = 0; i < NQW; i++) if (mem[i] !== ref_mem[i]) mism++;
        chk(mem[d >> 3] === ref_mem[d >> 3], "R2 R4 R6 destination quadword", mem[d >> 3], ref_mem[d >> 3]);
        chk(mism == 0, "R5 R7 untouched memory", 64'(mism), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NQW; i++) ref_mem[i] = seed_qw(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && mem_req_valid == 0, "reset state",
            {61'd0, busy, done, mem_req_valid}, 64'd0);

        // R10 worked example
        run_op(12'h103, 12'h20d, 1'b0);
        chk(mem[65] === 64'hFFEE89CCBBAA9988, "R10 example result", mem[65], 64'hFFEE89CCBBAA9988);

        // R2 R4 R5: all lane pairs in separate quadwords, memory always ready
        for (int sl = 0; sl < 8; sl++)
            for (int dl = 0; dl < 8; dl++)
                run_op(AW'(((100 + sl*8 + dl) << 3) | sl), AW'(((300 + sl*8 + dl) << 3) | dl), 1'b0);

        // R6 R9: same quadword (diagonal = equal addresses), memory stalling
        stall_mode = 1'b1;
        for (int sl = 0; sl < 8; sl++)
            for (int dl = 0; dl < 8; dl++)
                run_op(AW'(((200 + sl*8 + dl) << 3) | sl), AW'(((200 + sl*8 + dl) << 3) | dl), 1'b0);

        // R7: start pulses during a stalled copy
        for (int k = 0; k < 6; k++)
            run_op(AW'(((400 + k) << 3) | k), AW'(((450 + k) << 3) | (7 - k)), 1'b1);

        summary();
        $finish;
    end
endmodule